// File: doc/BRIEF.md
# Configuration Startup Sequencer

This block steps a reconfigurable device through the phases that lead from an empty configuration memory to a running design. It wipes the memory one frame per clock while the active-low program request is held. When the request is released, it completes the sweep in progress and then runs one more full sweep. It then releases the open-drain init line and waits until that line is really high. At that point it latches the three mode pins and waits for the loader to report that the bitstream is complete.

After that report, the block releases the open-drain done line. Start-up proceeds only once the done line is sensed high. The other devices on the line can therefore hold it low to stall start-up. Once done is high, the block releases global initialization, and one clock later it enables the outputs. A new program request at any point sends the block straight back to clearing. The bitstream loader and the memory array are outside this block. The block only gives them a strobe, a frame index and the latched mode.

Top module: `cfg_startup_seq`

## Requirements
- R1: While rstN is low, the block is in the clearing phase. In this phase initHoldLow=1, clearStrobe=1, clearFrame=0, doneOut=0, globalInitRel=0, outputsEn=0 and cfgMode=0.
- R2: While programN is low, clearing repeats without end. clearFrame advances by one each clock from 0 to FRAMES-1 and wraps to 0, and initHoldLow stays 1.
- R3: When programN goes high while clearFrame shows k, clearStrobe stays high for exactly 2*FRAMES-k clocks, counting the clock showing k. This covers the rest of the current sweep and one complete extra sweep. initHoldLow falls in the clock after the last of them.
- R4: After clearing, initHoldLow is 0. While initSense stays low, the block stays waiting. In that state cfgMode keeps its value and dataDone has no effect on doneOut.
- R5: cfgMode takes modePins on the clock edge at which initSense is first seen high in the waiting state. Later changes on modePins leave cfgMode unchanged.
- R6: cclkDrive is 1 only while the block waits for data completion with a latched mode of 3'b000, 3'b001 or 3'b011, which are the modes where the device drives the configuration clock. For every other code (including 3'b100, 3'b101 and 3'b111), and in every other phase, it is 0.
- R7: A dataDone pulse in the data-loading phase makes doneOut 1 from the next clock onward.
- R8: While doneOut is 1 and doneSense is low, globalInitRel and outputsEn stay 0.
- R9: One clock after doneSense is seen high with doneOut=1, globalInitRel becomes 1. One clock after that, outputsEn becomes 1. Both then stay 1.
- R10: When programN is low at a clock edge in any phase other than clearing, the next clock shows clearing with clearFrame=0, initHoldLow=1 and doneOut, globalInitRel and outputsEn all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| programN | input | 1 | Active-low request to clear and reconfigure |
| modePins | input | 3 | Mode selection pins, latched once |
| dataDone | input | 1 | Loader strobe: bitstream fully received |
| doneSense | input | 1 | Sensed level of the open-drain done line |
| initSense | input | 1 | Sensed level of the open-drain init line |
| initHoldLow | output | 1 | 1 = block pulls the init line low |
| doneOut | output | 1 | 1 = block releases the done line (configuration complete) |
| clearStrobe | output | 1 | Clear the frame at clearFrame this clock |
| clearFrame | output | $clog2(FRAMES) | Index of the frame being cleared |
| cfgMode | output | 3 | Latched configuration mode |
| cclkDrive | output | 1 | 1 = configuration clock is driven by the device |
| globalInitRel | output | 1 | Release of global logic initialization |
| outputsEn | output | 1 | Enable of user outputs |

## Verification
The hardest situations to reach are the two release points of the program request: one mid-sweep and one on the very last frame of a sweep. These set the length of the extra clearing, and the bench counts the strobe cycles for each. Both the init and done lines are modelled in the bench as wired levels. The block's own drive is ANDed with an external hold, so the stall in waiting and the stall before start-up come from an outside device keeping the line low. A second program request then lands in the data-loading phase and also in the running phase, to reach the abort path from states well beyond clearing.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_FINAL,
    ST_WAIT,
    ST_LOAD,
    ST_DONE,
    ST_GINIT,
    ST_RUN
  } seqState_t;

  typedef struct packed {
    logic cntZero;
    logic cntStep;
    logic modeCapture;
  } seqStrobe_t;

  localparam logic [2:0] MODE_MSER  = 3'b000;
  localparam logic [2:0] MODE_MPAR  = 3'b001;
  localparam logic [2:0] MODE_APER  = 3'b011;

  function automatic logic modeDrivesClk(input logic [2:0] m);
    case (m)
      MODE_MSER, MODE_MPAR, MODE_APER: modeDrivesClk = 1'b1;
      default:                         modeDrivesClk = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cfg_seq_dp.sv
module cfg_seq_dp
  import cfg_seq_pkg::*;
#(
  parameter int FRAMES = 512
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strobes,
  input  logic [2:0]                modePins,
  output logic                      passEnd,
  output logic [$clog2(FRAMES)-1:0] frameIdx,
  output logic [2:0]                modeReg,
  output logic                      masterClk
);

  localparam int CNT_W = $clog2(FRAMES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.cntZero) begin
      cnt <= '0;
    end else if (strobes.cntStep) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
    end else if (strobes.modeCapture) begin
      modeReg <= modePins;
    end
  end

  assign passEnd   = (cnt == LAST);
  assign frameIdx  = cnt;
  assign masterClk = modeDrivesClk(modeReg);

  // R2
  frame_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.modeCapture |=> $stable(modeReg));

  // R10
  abort_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntZero |=> (cnt == '0));

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       programN,
  input  logic       initSense,
  input  logic       doneSense,
  input  logic       dataDone,
  input  logic       passEnd,
  output seqStrobe_t strobes,
  output logic       initHoldLow,
  output logic       clearStrobe,
  output logic       doneOut,
  output logic       globalInitRel,
  output logic       outputsEn,
  output logic       loadPhase
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CLEAR;
    else       state <= nextState;
  end

  always_comb begin
    nextState           = state;
    strobes             = '0;
    if (!programN) begin
      nextState         = ST_CLEAR;
      strobes.cntZero   = (state != ST_CLEAR);
      strobes.cntStep   = (state == ST_CLEAR);
    end else begin
      case (state)
        ST_CLEAR: begin
          strobes.cntStep = 1'b1;
          if (passEnd) nextState = ST_FINAL;
        end
        ST_FINAL: begin
          strobes.cntStep = 1'b1;
          if (passEnd) nextState = ST_WAIT;
        end
        ST_WAIT: begin
          if (initSense) begin
            nextState           = ST_LOAD;
            strobes.modeCapture = 1'b1;
          end
        end
        ST_LOAD:  if (dataDone)  nextState = ST_DONE;
        ST_DONE:  if (doneSense) nextState = ST_GINIT;
        ST_GINIT: nextState = ST_RUN;
        ST_RUN:   nextState = ST_RUN;
        default:  nextState = ST_CLEAR;
      endcase
    end
  end

  assign clearStrobe   = (state == ST_CLEAR) || (state == ST_FINAL);
  assign initHoldLow   = clearStrobe;
  assign loadPhase     = (state == ST_LOAD);
  assign doneOut       = (state == ST_DONE) || (state == ST_GINIT) || (state == ST_RUN);
  assign globalInitRel = (state == ST_GINIT) || (state == ST_RUN);
  assign outputsEn     = (state == ST_RUN);

  // R10
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !programN |=> (state == ST_CLEAR));

  // R3
  extra_pass_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CLEAR && !passEnd) |=> (state != ST_FINAL));

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !initSense && programN) |=> (state == ST_WAIT));

  // R8
  done_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && !doneSense && programN) |=> !globalInitRel);

  // R9
  start_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outputsEn) |-> $past(globalInitRel));

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfg_seq_pkg::*;
#(
  parameter int FRAMES = 512
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      programN,
  input  logic [2:0]                modePins,
  input  logic                      dataDone,
  input  logic                      doneSense,
  input  logic                      initSense,
  output logic                      initHoldLow,
  output logic                      doneOut,
  output logic                      clearStrobe,
  output logic [$clog2(FRAMES)-1:0] clearFrame,
  output logic [2:0]                cfgMode,
  output logic                      cclkDrive,
  output logic                      globalInitRel,
  output logic                      outputsEn
);

  seqStrobe_t strobes;
  logic       passEnd;
  logic       loadPhase;
  logic       masterClk;

  cfg_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .programN     (programN),
    .initSense    (initSense),
    .doneSense    (doneSense),
    .dataDone     (dataDone),
    .passEnd      (passEnd),
    .strobes      (strobes),
    .initHoldLow  (initHoldLow),
    .clearStrobe  (clearStrobe),
    .doneOut      (doneOut),
    .globalInitRel(globalInitRel),
    .outputsEn    (outputsEn),
    .loadPhase    (loadPhase)
  );

  cfg_seq_dp #(.FRAMES(FRAMES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .modePins (modePins),
    .passEnd  (passEnd),
    .frameIdx (clearFrame),
    .modeReg  (cfgMode),
    .masterClk(masterClk)
  );

  assign cclkDrive = loadPhase && masterClk;

  // R6
  cclk_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    cclkDrive |-> (!clearStrobe && !doneOut));

endmodule

// File: tb/cfg_startup_seq_bench.sv
module cfg_startup_seq_bench;

  localparam int F      = 8;
  localparam int CLK_NS = 8;

  localparam int FL_INIT = 0, FL_CLR = 1, FL_FRM = 2, FL_DONE = 3,
                 FL_GINIT = 4, FL_OUTEN = 5, FL_MODE = 6, FL_CCLK = 7;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       programN = 1'b0;
  logic [2:0] modePins = 3'b000;
  logic       dataDone = 1'b0;
  logic       extInitLow = 1'b1;
  logic       extDoneLow = 1'b0;
  logic       doneSense, initSense;
  logic       initHoldLow, doneOut, clearStrobe, cclkDrive, globalInitRel, outputsEn;
  logic [2:0] clearFrame;
  logic [2:0] cfgMode;

  int nChecks = 0;
  int nErrors = 0;

  typedef struct {
    string tag;
    int    fld;
    int    exp;
  } sbItem_t;
  sbItem_t sbq[$];

  always #(CLK_NS/2) clk = ~clk;

  assign initSense = !initHoldLow && !extInitLow;
  assign doneSense = doneOut && !extDoneLow;

  cfg_startup_seq #(.FRAMES(F)) u_cfg_startup_seq (
    .clk(clk), .rstN(rstN), .programN(programN), .modePins(modePins),
    .dataDone(dataDone), .doneSense(doneSense), .initSense(initSense),
    .initHoldLow(initHoldLow), .doneOut(doneOut), .clearStrobe(clearStrobe),
    .clearFrame(clearFrame), .cfgMode(cfgMode), .cclkDrive(cclkDrive),
    .globalInitRel(globalInitRel), .outputsEn(outputsEn)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expectNext(input string tag, input int fld, input int exp);
    sbq.push_back('{tag, fld, exp});
  endtask

  function automatic int probe(input int fld);
    case (fld)
      FL_INIT:  probe = int'(initHoldLow);
      FL_CLR:   probe = int'(clearStrobe);
      FL_FRM:   probe = int'(clearFrame);
      FL_DONE:  probe = int'(doneOut);
      FL_GINIT: probe = int'(globalInitRel);
      FL_OUTEN: probe = int'(outputsEn);
      FL_MODE:  probe = int'(cfgMode);
      default:  probe = int'(cclkDrive);
    endcase
  endfunction

  // monitor: compares queued expectations shortly after each active edge
  always @(posedge clk) begin
    sbItem_t it;
    #2;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      check(it.tag, probe(it.fld), it.exp);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic countClear(input string tag, input int exp);
    int n = 0;
    while (clearStrobe && n < 4*F) begin
      n++;
      tick();
    end
    check(tag, n, exp);
  endtask

  initial begin
    #(CLK_NS * 150000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    int expCnt;
    // R1 reset state
    expectNext("R1 init", FL_INIT, 1);
    expectNext("R1 strobe", FL_CLR, 1);
    expectNext("R1 frame", FL_FRM, 0);
    expectNext("R1 done", FL_DONE, 0);
    expectNext("R1 ginit", FL_GINIT, 0);
    expectNext("R1 outen", FL_OUTEN, 0);
    expectNext("R1 mode", FL_MODE, 0);
    tick();
    rstN = 1'b1;
    expCnt = 0;

    // R2 repeated sweeps while program held low
    for (int i = 0; i < 2*F + 3; i++) begin
      expCnt = (expCnt + 1) % F;
      expectNext("R2 frame", FL_FRM, expCnt);
      expectNext("R2 init", FL_INIT, 1);
      tick();
    end

    // R3 release mid-sweep at frame 3
    while (int'(clearFrame) != 3) tick();
    programN = 1'b1;
    countClear("R3 mid-sweep", 2*F - 3);
    check("R4 init released", int'(initHoldLow), 0);

    // R4 waiting while init held low externally
    dataDone = 1'b1;
    modePins = 3'b001;
    expectNext("R4 done", FL_DONE, 0);
    expectNext("R4 mode", FL_MODE, 0);
    tick();
    dataDone = 1'b0;
    for (int i = 0; i < 8; i++) begin
      expectNext("R4 init", FL_INIT, 0);
      expectNext("R4 mode", FL_MODE, 0);
      tick();
    end

    // R5/R6 mode latch on init high
    modePins = 3'b011;
    extInitLow = 1'b0;
    expectNext("R5 mode", FL_MODE, 3);
    expectNext("R6 master", FL_CCLK, 1);
    tick();
    modePins = 3'b111;
    expectNext("R5 mode stable", FL_MODE, 3);
    tick();

    // R7/R8 done with external stall
    extDoneLow = 1'b1;
    dataDone = 1'b1;
    expectNext("R7 done", FL_DONE, 1);
    expectNext("R6 after load", FL_CCLK, 0);
    expectNext("R8 ginit", FL_GINIT, 0);
    tick();
    dataDone = 1'b0;
    for (int i = 0; i < 5; i++) begin
      expectNext("R8 ginit", FL_GINIT, 0);
      expectNext("R8 outen", FL_OUTEN, 0);
      expectNext("R7 done held", FL_DONE, 1);
      tick();
    end

    // R9 start-up ordering
    extDoneLow = 1'b0;
    expectNext("R9 ginit", FL_GINIT, 1);
    expectNext("R9 outen early", FL_OUTEN, 0);
    tick();
    expectNext("R9 outen", FL_OUTEN, 1);
    expectNext("R9 ginit kept", FL_GINIT, 1);
    tick();

    // R10 abort from running
    programN = 1'b0;
    expectNext("R10 frame", FL_FRM, 0);
    expectNext("R10 init", FL_INIT, 1);
    expectNext("R10 done", FL_DONE, 0);
    expectNext("R10 ginit", FL_GINIT, 0);
    expectNext("R10 outen", FL_OUTEN, 0);
    tick();
    expectNext("R2 frame after abort", FL_FRM, 1);
    tick();

    // R3 release on last frame of a sweep
    while (int'(clearFrame) != F-1) tick();
    modePins = 3'b101;
    programN = 1'b1;
    countClear("R3 last frame", F + 1);

    // R5/R6 non-driving mode
    expectNext("R5 mode", FL_MODE, 5);
    expectNext("R6 slave", FL_CCLK, 0);
    tick();

    // R10 abort from loading phase
    programN = 1'b0;
    expectNext("R10 load init", FL_INIT, 1);
    expectNext("R10 load strobe", FL_CLR, 1);
    expectNext("R10 load frame", FL_FRM, 0);
    tick();
    tick();

    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule